// File: doc/BRIEF.md
# JTAG Test Access Port with Instruction-Selected Data Registers

This block is a JTAG test access port. It runs the standard sixteen-state controller from TCK and TMS and holds a 3-bit instruction. The instruction decides which serial register sits between TDI and TDO while the controller is in Shift-DR. There are three candidates: a single bypass cell, a 10-bit debug register and a 3-bit programming register. The two private registers each have a parallel output buffer, a parallel input and a one-cycle update strobe toward the system side. Boundary-scan cells, the debug engine and the bootloader are outside the block.

A host first loads an instruction with an IR scan. Its DR scans then move data through the selected register. Three codes are no-ops, and they keep whichever register was selected before. In Update-DR, on the falling TCK edge, the shifted pattern goes to the parallel output and the parallel input is sampled. The sampled value is what the next DR scan shifts out.

Top module: `jtag_tap_top`

## Requirements
- R1: Holding trstN low, or five rising TCK edges with TMS high, puts the controller in Test-Logic-Reset. There the instruction becomes 3'b011 (bypass), the bypass cell is selected and tdoEn is low. An asynchronous reset also clears both parallel outputs and both strobes.
- R2: In Capture-IR the instruction shift register loads 3'b001, and it shifts LSB first. The new code takes effect only on the falling edge in Update-IR.
- R3: Code 3'b010 selects the 10-bit debug register between TDI and TDO.
- R4: Code 3'b100 selects the 3-bit programming register between TDI and TDO.
- R5: Codes 3'b011, 3'b101 and 3'b111 select the single bypass cell. The cell loads 0 in Capture-DR, so a scan returns 0 followed by TDI delayed by one bit. A bypass scan leaves dbgOut and prgOut unchanged and raises no strobe.
- R6: Codes 3'b000, 3'b001 and 3'b110 keep the data register that was selected before the IR scan.
- R7: On the falling TCK edge in Update-DR, the selected register's parallel output takes the shifted pattern, with the first TDI bit at bit 0. The parallel input is sampled on that same edge, and the next DR scan of that register shifts it out LSB first.
- R8: The update strobe of the selected private register is high for exactly one TCK cycle after its Update-DR falling edge. The other register's strobe stays low.
- R9: DR scans never change the instruction or the data-register selection.
- R10: TDO changes on the falling TCK edge. tdoEn is high only while the controller is in Shift-IR or Shift-DR. Bits leave LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdoEn | output | 1 | High while tdo carries shift data |
| dbgIn | input | 10 | Debug parallel input, sampled at Update-DR |
| dbgOut | output | 10 | Debug parallel output buffer |
| dbgUpd | output | 1 | One-cycle strobe when dbgOut is updated |
| prgIn | input | 3 | Programming parallel input, sampled at Update-DR |
| prgOut | output | 3 | Programming parallel output buffer |
| prgUpd | output | 1 | One-cycle strobe when prgOut is updated |

## Verification
The bench drives TMS and TDI two nanoseconds after each rising edge and reads TDO three nanoseconds after the falling edge. A bit read in a Shift-state cycle is therefore the bit that leaves on the following rising edge. Parallel outputs and strobes are due at the falling edge of the Update cycle. The bench reads them in the first Run-Test/Idle cycle and reads the strobe again one cycle later, when it must be low. Values sampled from the parallel inputs are due one full scan later, so the model records the input that was present at each update and compares it with the bits of the next scan.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
  localparam logic [IR_W-1:0] CODE_DBG   = 3'b010;
  localparam logic [IR_W-1:0] CODE_PRG   = 3'b100;
  localparam logic [IR_W-1:0] CODE_BYP   = 3'b011;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {DR_BYP, DR_DBG, DR_PRG} drSel_e;

  typedef struct packed {
    logic testReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStb_t;

  // no-op and reserved codes keep the current path
  function automatic drSel_e nextSel(input logic [IR_W-1:0] code, input drSel_e cur);
    case (code)
      3'b010:                 return DR_DBG;
      3'b100:                 return DR_PRG;
      3'b011, 3'b101, 3'b111: return DR_BYP;
      default:                return cur;
    endcase
  endfunction

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import jtag_tap_pkg::*;
(
  input  logic      tck,
  input  logic      trstN,
  input  logic      tms,
  output tapState_e state,
  output tapStb_t   stb
);

  tapState_e nextState;

  always_comb begin
    case (state)
      TLR:     nextState = tms ? TLR    : RTI;
      RTI:     nextState = tms ? SEL_DR : RTI;
      SEL_DR:  nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nextState = tms ? EX1_DR : SH_DR;
      SH_DR:   nextState = tms ? EX1_DR : SH_DR;
      EX1_DR:  nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nextState = tms ? UPD_DR : SH_DR;
      UPD_DR:  nextState = tms ? SEL_DR : RTI;
      SEL_IR:  nextState = tms ? TLR    : CAP_IR;
      CAP_IR:  nextState = tms ? EX1_IR : SH_IR;
      SH_IR:   nextState = tms ? EX1_IR : SH_IR;
      EX1_IR:  nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nextState = tms ? UPD_IR : SH_IR;
      UPD_IR:  nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TLR;
    else        state <= nextState;
  end

  always_comb begin
    stb.testReset = (state == TLR);
    stb.captureIr = (state == CAP_IR);
    stb.shiftIr   = (state == SH_IR);
    stb.updateIr  = (state == UPD_IR);
    stb.captureDr = (state == CAP_DR);
    stb.shiftDr   = (state == SH_DR);
    stb.updateDr  = (state == UPD_DR);
  end

endmodule

// File: rtl/tap_pdr.sv
module tap_pdr #(
  parameter int W = 10
) (
  input  logic         tck,
  input  logic         trstN,
  input  logic         selected,
  input  logic         shiftEn,
  input  logic         updEn,
  input  logic         tdi,
  input  logic [W-1:0] parIn,
  output logic         serOut,
  output logic [W-1:0] parOut,
  output logic         updStb
);

  logic [W-1:0] shReg;
  logic [W-1:0] holdReg;

  // rising edge: shift, or reload from the value sampled at Update-DR
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shReg <= '0;
    end else if (selected) begin
      if (shiftEn)    shReg <= {tdi, shReg[W-1:1]};
      else if (updEn) shReg <= holdReg;
    end
  end

  // falling edge in Update-DR: publish pattern, sample parallel input
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      parOut  <= '0;
      holdReg <= '0;
      updStb  <= 1'b0;
    end else begin
      updStb <= selected && updEn;
      if (selected && updEn) begin
        parOut  <= shReg;
        holdReg <= parIn;
      end
    end
  end

  assign serOut = shReg[0];

endmodule

// File: rtl/tap_dpath.sv
module tap_dpath
  import jtag_tap_pkg::*;
#(
  parameter int DBG_W = 10,
  parameter int PRG_W = 3
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  tapStb_t          stb,
  input  logic [DBG_W-1:0] dbgIn,
  input  logic [PRG_W-1:0] prgIn,
  output logic             tdo,
  output logic             tdoEn,
  output logic [DBG_W-1:0] dbgOut,
  output logic             dbgUpd,
  output logic [PRG_W-1:0] prgOut,
  output logic             prgUpd,
  output logic [IR_W-1:0]  irCode
);

  logic [IR_W-1:0] irShift;
  drSel_e          drSel;
  logic            bypCell;
  logic            dbgSer, prgSer;
  logic            drBit;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            irShift <= IR_CAPTURE;
    else if (stb.captureIr) irShift <= IR_CAPTURE;
    else if (stb.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                              bypCell <= 1'b0;
    else if (stb.captureDr)                  bypCell <= 1'b0;
    else if (stb.shiftDr && drSel == DR_BYP) bypCell <= tdi;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      irCode <= CODE_BYP;
      drSel  <= DR_BYP;
    end else if (stb.testReset) begin
      irCode <= CODE_BYP;
      drSel  <= DR_BYP;
    end else if (stb.updateIr) begin
      irCode <= irShift;
      drSel  <= nextSel(irShift, drSel);
    end
  end

  tap_pdr #(.W(DBG_W)) u_dbg (
    .tck(tck), .trstN(trstN), .selected(drSel == DR_DBG),
    .shiftEn(stb.shiftDr), .updEn(stb.updateDr), .tdi(tdi),
    .parIn(dbgIn), .serOut(dbgSer), .parOut(dbgOut), .updStb(dbgUpd)
  );

  tap_pdr #(.W(PRG_W)) u_prg (
    .tck(tck), .trstN(trstN), .selected(drSel == DR_PRG),
    .shiftEn(stb.shiftDr), .updEn(stb.updateDr), .tdi(tdi),
    .parIn(prgIn), .serOut(prgSer), .parOut(prgOut), .updStb(prgUpd)
  );

  always_comb begin
    case (drSel)
      DR_DBG:  drBit = dbgSer;
      DR_PRG:  drBit = prgSer;
      default: drBit = bypCell;
    endcase
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= stb.shiftIr || stb.shiftDr;
      if (stb.shiftIr)      tdo <= irShift[0];
      else if (stb.shiftDr) tdo <= drBit;
    end
  end

endmodule

// File: rtl/jtag_tap_top.sv
module jtag_tap_top
  import jtag_tap_pkg::*;
#(
  parameter int DBG_W = 10,
  parameter int PRG_W = 3
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdoEn,
  input  logic [DBG_W-1:0] dbgIn,
  output logic [DBG_W-1:0] dbgOut,
  output logic             dbgUpd,
  input  logic [PRG_W-1:0] prgIn,
  output logic [PRG_W-1:0] prgOut,
  output logic             prgUpd
);

  tapState_e       tapState;
  tapStb_t         stb;
  logic [IR_W-1:0] irCode;

  tap_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms), .state(tapState), .stb(stb)
  );

  tap_dpath #(.DBG_W(DBG_W), .PRG_W(PRG_W)) u_dpath (
    .tck(tck), .trstN(trstN), .tdi(tdi), .stb(stb),
    .dbgIn(dbgIn), .prgIn(prgIn), .tdo(tdo), .tdoEn(tdoEn),
    .dbgOut(dbgOut), .dbgUpd(dbgUpd), .prgOut(prgOut), .prgUpd(prgUpd),
    .irCode(irCode)
  );

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
#(
  parameter int DBG_W = 10,
  parameter int PRG_W = 3
) (
  input logic             tck,
  input logic             trstN,
  input logic             tdoEn,
  input logic [DBG_W-1:0] dbgOut,
  input logic             dbgUpd,
  input logic [PRG_W-1:0] prgOut,
  input logic             prgUpd,
  input tapState_e        tapState,
  input logic [IR_W-1:0]  irCode
);

  // R1
  tlr_forces_bypass_chk: assert property (@(negedge tck) disable iff (!trstN)
    (tapState == TLR) |=> (irCode == CODE_BYP));

  // R9
  dr_keeps_ir_chk: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == UPD_DR) |=> $stable(irCode));

  // R7
  dbg_out_only_on_update_chk: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(dbgOut) |-> dbgUpd);

  // R7
  prg_out_only_on_update_chk: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(prgOut) |-> prgUpd);

  // R8
  dbg_strobe_single_chk: assert property (@(negedge tck) disable iff (!trstN)
    dbgUpd |=> !dbgUpd);

  // R8
  prg_strobe_single_chk: assert property (@(negedge tck) disable iff (!trstN)
    prgUpd |=> !prgUpd);

  // R8
  strobes_exclusive_chk: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({dbgUpd, prgUpd}));

  // R10
  tdo_enable_shift_only_chk: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (tapState == SH_IR || tapState == SH_DR));

endmodule

bind jtag_tap_top jtag_tap_chk #(.DBG_W(DBG_W), .PRG_W(PRG_W)) u_chk (
  .tck(tck), .trstN(trstN), .tdoEn(tdoEn), .dbgOut(dbgOut), .dbgUpd(dbgUpd),
  .prgOut(prgOut), .prgUpd(prgUpd), .tapState(tapState), .irCode(irCode)
);

// File: tb/sim_jtag_tap_top.sv
module sim_jtag_tap_top;

  logic       tck = 1'b0;
  logic       trstN = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       tdo, tdoEn;
  logic [9:0] dbgIn = 10'h000;
  logic [9:0] dbgOut;
  logic       dbgUpd;
  logic [2:0] prgIn = 3'b000;
  logic [2:0] prgOut;
  logic       prgUpd;

  int nChk = 0;
  int nErr = 0;
  logic lastEn;

  // model: 0 bypass, 1 debug, 2 programming
  int         mSel = 0;
  logic [9:0] mDbgSh = '0, mDbgOut = '0;
  logic [2:0] mPrgSh = '0, mPrgOut = '0;

  always #4 tck = ~tck;

  jtag_tap_top u0 (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .dbgIn(dbgIn), .dbgOut(dbgOut), .dbgUpd(dbgUpd),
    .prgIn(prgIn), .prgOut(prgOut), .prgUpd(prgUpd)
  );

  function automatic int expSel(input logic [2:0] code, input int cur);
    case (code)
      3'b010:                 return 1;
      3'b100:                 return 2;
      3'b011, 3'b101, 3'b111: return 0;
      default:                return cur;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called 2 ns after a rising edge; TDO read 3 ns after the falling edge
  task automatic tick(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    #5;
    o = tdo;
    lastEn = tdoEn;
    @(posedge tck);
    #2;
  endtask

  task automatic scanIr(input logic [2:0] code);
    logic o;
    logic [2:0] got;
    logic en;
    en = 1'b1;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i], o);
      got[i] = o;
      if (!lastEn) en = 1'b0;
    end
    tick(1, 0, o); tick(0, 0, o);
    chk("R2 IR capture value", {29'd0, got}, 32'd1);
    chk("R10 tdoEn in Shift-IR", {31'd0, en}, 32'd1);
    mSel = expSel(code, mSel);
  endtask

  task automatic scanDr(input int len, input logic [15:0] data, input string req);
    logic o;
    logic en;
    logic [15:0] got, exp;
    got = '0; exp = '0; en = 1'b1;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, data[i], o);
      got[i] = o;
      if (!lastEn) en = 1'b0;
    end
    tick(1, 0, o); tick(0, 0, o);
    case (mSel)
      1:       exp[9:0] = mDbgSh;
      2:       exp[2:0] = mPrgSh;
      default: for (int i = 1; i < len; i++) exp[i] = data[i-1];
    endcase
    chk({req, " shifted-out bits"}, {16'd0, got}, {16'd0, exp});
    chk("R10 tdoEn in Shift-DR", {31'd0, en}, 32'd1);
    if (mSel == 1) begin mDbgOut = data[9:0]; mDbgSh = dbgIn; end
    if (mSel == 2) begin mPrgOut = data[2:0]; mPrgSh = prgIn; end
    chk("R7 dbgOut after update", {22'd0, dbgOut}, {22'd0, mDbgOut});
    chk("R7 prgOut after update", {29'd0, prgOut}, {29'd0, mPrgOut});
    chk("R8 strobes in update cycle", {30'd0, dbgUpd, prgUpd},
        {30'd0, mSel == 1, mSel == 2});
    tick(0, 0, o);
    chk("R8 strobes one cycle later", {30'd0, dbgUpd, prgUpd}, 32'd0);
    chk("R10 tdoEn idle", {31'd0, tdoEn}, 32'd0);
  endtask

  task automatic scanSel(input logic [15:0] data, input string req);
    int len;
    len = (mSel == 1) ? 10 : (mSel == 2) ? 3 : 1 + int'($urandom % 8);
    scanDr(len, data, req);
  endtask

  task automatic tmsReset();
    logic o;
    repeat (5) tick(1, 0, o);
    tick(0, 0, o);
    mSel = 0;
    chk("R1 tdoEn after TMS reset", {31'd0, tdoEn}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    nChk++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

  initial begin
    logic o;
    void'($urandom(32'h00c0ffee));
    repeat (3) @(posedge tck);
    #2;
    chk("R1 reset tdoEn", {31'd0, tdoEn}, 32'd0);
    chk("R1 reset outputs", {19'd0, dbgOut, prgOut}, 32'd0);
    chk("R1 reset strobes", {30'd0, dbgUpd, prgUpd}, 32'd0);
    trstN = 1'b1;
    tick(0, 0, o);

    // R5 bypass after reset: 0 then delayed TDI
    scanDr(6, 16'h002d, "R5 bypass after reset");

    // R3 debug register, R7 reload path
    dbgIn = 10'h3a5;
    scanIr(3'b010);
    scanDr(10, 16'h02c3, "R3 debug first scan");
    dbgIn = 10'h15a;
    scanDr(10, 16'h0155, "R7 debug reload");
    scanDr(10, 16'h03ff, "R9 debug still selected");

    // R6 no-op and reserved codes keep debug
    scanIr(3'b000);
    scanDr(10, 16'h0001, "R6 code 000 keeps debug");
    scanIr(3'b001);
    scanDr(10, 16'h0200, "R6 code 001 keeps debug");
    scanIr(3'b110);
    scanDr(10, 16'h0123, "R6 code 110 keeps debug");

    // R4 programming register
    prgIn = 3'b110;
    scanIr(3'b100);
    scanDr(3, 16'h0005, "R4 programming first scan");
    prgIn = 3'b011;
    scanDr(3, 16'h0002, "R4 programming reload");
    scanIr(3'b000);
    scanDr(3, 16'h0007, "R6 code 000 keeps programming");

    // R5 all bypass codes, outputs untouched
    scanIr(3'b101);
    scanDr(4, 16'h0009, "R5 bypass code 101");
    scanIr(3'b111);
    scanDr(3, 16'h0006, "R5 bypass code 111");
    scanIr(3'b011);
    scanDr(8, 16'h00b7, "R5 bypass code 011");

    // R1 TMS reset from debug selection
    scanIr(3'b010);
    tmsReset();
    scanDr(5, 16'h0013, "R1 bypass after TMS reset");

    // random mix
    for (int k = 0; k < 120; k++) begin
      case ($urandom % 6)
        0: scanIr(3'($urandom % 8));
        1, 2: scanSel(16'($urandom), "R9 random DR scan");
        3: begin
          dbgIn = 10'($urandom);
          prgIn = 3'($urandom);
        end
        4: if ($urandom % 4 == 0) tmsReset();
        default: begin
          scanIr(($urandom % 2 == 0) ? 3'b010 : 3'b100);
          scanSel(16'($urandom), "R3 R4 random private scan");
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

endmodule